// File: doc/BRIEF.md
# NAND Flash Host Controller

This block sits on a 32-bit register bus and turns register accesses into bus cycles on a NAND flash device. The offset of an access picks the bus phase. A write to the command offset issues one command-latch cycle. A write to the address offset issues one address-latch cycle. An access to the data offset moves the whole 32-bit word over the flash bus: four byte cycles on an 8-bit bank, or two halfword cycles on a 16-bit bank, most significant part first. The register bus waits on a ready pulse until every flash cycle of the access has ended.

A control register picks which of four chip enables is driven low, and it can release all of them. Each bank has a configuration register with an enable bit and a bus width bit. A status register shows the synchronized ready/busy line. A timing register sets how many clocks each write or read strobe stays low, and then high.

While data moves on an 8-bit bank, a Hamming accumulator covers every byte. It builds 16 line-parity bits and 6 column-parity bits for a 256-byte chunk. Software clears the accumulator before a chunk and reads the three ECC bytes after it.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset all chip enables are high, the write and read strobes are high, the command and address latch outputs are low, ready_o is low and io_oe_o is low. The control register reads 0x80000000 (enables released, bank 0).
- R2: A write to offset 0x00 on an enabled bank gives exactly one strobe cycle. During it cle_o is high, ale_o is low, io_oe_o is high and io_o[7:0] holds wdata_i[7:0]. we_no is low for the programmed count of clocks.
- R3: A write to offset 0x04 gives exactly one strobe cycle with ale_o high, cle_o low and io_o[7:0] equal to wdata_i[7:0]. cle_o and ale_o are never high together.
- R4: Writing the control register (offset 0x40) with bit 31 clear drives low only the chip enable chosen by bits 25:24. Writing it with bit 31 set drives all chip enables high. Readback holds bit 31 and bits 25:24 and zero elsewhere.
- R5: A data write (offset 0x08) to an 8-bit bank gives four we_no cycles with io_o[7:0] carrying bits 31:24, 23:16, 15:8 and then 7:0, with both latch outputs low.
- R6: A data read from an 8-bit bank gives four re_no cycles with io_oe_o low. io_i[7:0] is sampled on the last clock of each low phase, and the bytes are packed into rdata_o with the first byte most significant.
- R7: A bank whose config bit 27 is 1 uses a 16-bit bus. A data access then makes two cycles on io[15:0], with the upper halfword first.
- R8: A data, command or address access gives no strobe when the enables are released or the selected bank's config bit 31 is 0. It still completes with a ready pulse, and a data read then returns 0.
- R9: The status register (offset 0x44) shows rb_i in bit 24 after a two-flop synchronizer, with all other bits 0.
- R10: The timing register (offset 0x48) holds in bits 3:0 the number of clocks each strobe stays low. Between two cycles of one access the strobe stays high for the same number of clocks. A value of 0 acts as 1. The reset value is 2.
- R11: The ECC register (offset 0x10) reads {col, lp[15:8], lp[7:0], 8'h00}. For a byte b at index i since the last clear, when b has odd parity it toggles lp[2k+1] for each set bit k of i and lp[2k] for each clear bit k of i. col = {cp5..cp0, 2'b11}, where cp0..cp5 are running parities over the data bit groups {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0..3} and {4..7}.
- R12: Writing control bit 30 clears the ECC, so it reads 0x03000000. Only data bytes that are actually strobed on an 8-bit bank change the ECC. Accesses made while the enables are released, and 16-bit bank transfers, leave it unchanged.
- R13: Bank config registers at 0x30, 0x34, 0x38 and 0x3C read back only bits 31 and 27, and reset to 0. The revision register at 0x50 reads the REV_ID parameter.
- R14: ready_o is high for exactly one clock per access. An access to a register that moves no flash data raises ready_o on the clock after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | One-clock access completion pulse |
| ce_no | output | 4 | Chip enables, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Flash write strobe, active low |
| re_no | output | 1 | Flash read strobe, active low |
| io_o | output | 16 | Flash data out |
| io_oe_o | output | 1 | Flash data output enable |
| io_i | input | 16 | Flash data in |
| rb_i | input | 1 | Flash ready/busy, 1 = ready |

## Verification
A wrong cycle count or shift state shows up inside the same access, as a missing or extra strobe or as bytes in the wrong order on io_o. The bench records every strobe edge and compares it within that access, in both bus widths and at three strobe lengths. A wrong ECC state shows nothing until the ECC register is read. The bench therefore reads it after a full 256-byte chunk, after a partial chunk of read bytes, and after accesses that must not touch it. It compares each read against an arithmetic parity model.

// File: rtl/nhc_pkg.sv
package nhc_pkg;
  localparam int BANKS = 4;
  localparam int SEL_W = 2;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_ADR  = 8'h04;
  localparam logic [7:0] OFS_DAT  = 8'h08;
  localparam logic [7:0] OFS_ECC  = 8'h10;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  localparam logic [7:0] OFS_TIME = 8'h48;
  localparam logic [7:0] OFS_REV  = 8'h50;

  localparam int CTRL_CE_REL  = 31;
  localparam int CTRL_ECC_CLR = 30;
  localparam int CTRL_SEL_LO  = 24;
  localparam int BANK_EN      = 31;
  localparam int BANK_WIDE    = 27;
  localparam int STAT_RDY     = 24;

  localparam logic [7:0] COL_MASK [6] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} fsm_e;
  typedef enum logic [1:0] {PH_DATA, PH_CMD, PH_ADR} phase_e;
  typedef enum logic [1:0] {SP_IDLE, SP_LOW, SP_HIGH} stb_e;
endpackage

// File: rtl/nhc_rb_sync.sv
module nhc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/nhc_strobe.sv
module nhc_strobe
  import nhc_pkg::*;
#(
  parameter int TIME_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [TIME_W-1:0] half_i,
  output logic              we_no,
  output logic              re_no,
  output logic              sample_o,
  output logic              done_o,
  output logic              busy_o
);
  stb_e              ph_q;
  logic [TIME_W-1:0] cnt_q;
  logic              rd_q;

  assign sample_o = (ph_q == SP_LOW)  && (cnt_q == '0);
  assign done_o   = (ph_q == SP_HIGH) && (cnt_q == '0);
  assign busy_o   = (ph_q != SP_IDLE);
  assign we_no    = !((ph_q == SP_LOW) && !rd_q);
  assign re_no    = !((ph_q == SP_LOW) && rd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= SP_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      case (ph_q)
        SP_IDLE: if (start_i) begin
          ph_q  <= SP_LOW;
          cnt_q <= half_i - TIME_W'(1);
          rd_q  <= rd_i;
        end
        SP_LOW: if (cnt_q == '0) begin
          ph_q  <= SP_HIGH;
          cnt_q <= half_i - TIME_W'(1);
        end else cnt_q <= cnt_q - TIME_W'(1);
        SP_HIGH: if (cnt_q == '0) begin
          if (start_i) begin
            ph_q  <= SP_LOW;
            cnt_q <= half_i - TIME_W'(1);
            rd_q  <= rd_i;
          end else ph_q <= SP_IDLE;
        end else cnt_q <= cnt_q - TIME_W'(1);
        default: ph_q <= SP_IDLE;
      endcase
    end
  end

  // strobe width counter never exceeds the programmed count
  assert_low_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < half_i));
endmodule

// File: rtl/nhc_ecc.sv
module nhc_ecc
  import nhc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [23:0] ecc_o
);
  logic [7:0]  idx_q;
  logic [15:0] lp_q, lp_d;
  logic [5:0]  cp_q, cp_d;
  logic        par;

  assign par = ^byte_i;

  for (genvar k = 0; k < 8; k++) begin : g_line
    assign lp_d[2*k+1] = lp_q[2*k+1] ^ (par & idx_q[k]);
    assign lp_d[2*k]   = lp_q[2*k]   ^ (par & ~idx_q[k]);
  end

  for (genvar c = 0; c < 6; c++) begin : g_col
    assign cp_d[c] = cp_q[c] ^ (^(byte_i & COL_MASK[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (en_i) begin
      idx_q <= idx_q + 8'd1;
      lp_q  <= lp_d;
      cp_q  <= cp_d;
    end
  end

  assign ecc_o = {cp_q, 2'b11, lp_q[15:8], lp_q[7:0]};
endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nhc_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          TIME_W      = 4,
  parameter int          DEF_HALF    = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] REV_ID      = 32'h0001_0300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic [BANKS-1:0]  ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [15:0]       io_o,
  output logic              io_oe_o,
  input  logic [15:0]       io_i,
  input  logic              rb_i
);
  fsm_e              state_q;
  phase_e            ph_q;
  logic              rd_q, wide_q;
  logic [2:0]        rem_q;
  logic [31:0]       sh_q, acc_q, reg_rd;
  logic              ce_rel_q;
  logic [SEL_W-1:0]  sel_q;
  logic [TIME_W-1:0] half_q, half_eff;
  logic [BANKS-1:0]  bank_en_q, bank_wide_q;
  logic              rb_q;
  logic              stb_start, stb_sample, stb_done, stb_busy;
  logic              ecc_en, ecc_clr;
  logic [7:0]        ecc_byte;
  logic [23:0]       ecc_w;

  logic [7:0]       ofs;
  logic             accept, flash_ok, sel_wide, bank_hit;
  logic [SEL_W-1:0] bank_idx;

  assign ofs      = addr_i[7:0];
  assign accept   = (state_q == ST_IDLE) && req_i;
  assign flash_ok = !ce_rel_q && bank_en_q[sel_q];
  assign sel_wide = bank_wide_q[sel_q];
  assign bank_hit = (ofs[7:4] == 4'h3) && (ofs[1:0] == 2'b00);
  assign bank_idx = ofs[3:2];
  assign half_eff = (half_q == '0) ? TIME_W'(1) : half_q;

  nhc_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rb_i), .q_o(rb_q));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_en_q[b]   <= 1'b0;
        bank_wide_q[b] <= 1'b0;
      end else if (accept && we_i && bank_hit && bank_idx == SEL_W'(b)) begin
        bank_en_q[b]   <= wdata_i[BANK_EN];
        bank_wide_q[b] <= wdata_i[BANK_WIDE];
      end
    end
    assign ce_no[b] = ce_rel_q | (sel_q != SEL_W'(b));
  end

  always_comb begin
    reg_rd = '0;
    case (ofs)
      OFS_ECC:  reg_rd = {ecc_w, 8'h00};
      OFS_CTRL: begin
        reg_rd[CTRL_CE_REL] = ce_rel_q;
        reg_rd[CTRL_SEL_LO +: SEL_W] = sel_q;
      end
      OFS_STAT: reg_rd[STAT_RDY] = rb_q;
      OFS_TIME: reg_rd[TIME_W-1:0] = half_q;
      OFS_REV:  reg_rd = REV_ID;
      default: if (bank_hit) begin
        reg_rd[BANK_EN]   = bank_en_q[bank_idx];
        reg_rd[BANK_WIDE] = bank_wide_q[bank_idx];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ph_q     <= PH_DATA;
      rd_q     <= 1'b0;
      wide_q   <= 1'b0;
      rem_q    <= '0;
      sh_q     <= '0;
      acc_q    <= '0;
      rdata_o  <= '0;
      ce_rel_q <= 1'b1;
      sel_q    <= '0;
      half_q   <= TIME_W'(DEF_HALF);
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          acc_q   <= '0;
          rd_q    <= !we_i;
          wide_q  <= sel_wide;
          rdata_o <= '0;
          state_q <= ST_DONE;
          if (ofs == OFS_DAT && flash_ok) begin
            state_q <= ST_XFER;
            ph_q    <= PH_DATA;
            rem_q   <= sel_wide ? 3'd2 : 3'd4;
            sh_q    <= wdata_i;
          end else if ((ofs == OFS_CMD || ofs == OFS_ADR) && we_i && flash_ok) begin
            state_q <= ST_XFER;
            ph_q    <= (ofs == OFS_CMD) ? PH_CMD : PH_ADR;
            rem_q   <= 3'd1;
            sh_q    <= sel_wide ? {8'h00, wdata_i[7:0], 16'h0000} : {wdata_i[7:0], 24'h0};
          end else if (!we_i) begin
            rdata_o <= reg_rd;
          end
          if (we_i && ofs == OFS_CTRL) begin
            ce_rel_q <= wdata_i[CTRL_CE_REL];
            sel_q    <= wdata_i[CTRL_SEL_LO +: SEL_W];
          end
          if (we_i && ofs == OFS_TIME) half_q <= wdata_i[TIME_W-1:0];
        end
        ST_XFER: begin
          if (stb_sample)
            acc_q <= wide_q ? {acc_q[15:0], io_i} : {acc_q[23:0], io_i[7:0]};
          if (stb_done) begin
            rem_q <= rem_q - 3'd1;
            sh_q  <= wide_q ? (sh_q << 16) : (sh_q << 8);
            if (rem_q == 3'd1) begin
              state_q <= ST_DONE;
              rdata_o <= rd_q ? acc_q : '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // back-to-back cycles chain straight from the end of the high phase
  assign stb_start = (state_q == ST_XFER) && (rem_q != '0) &&
                     (!stb_busy || (stb_done && rem_q > 3'd1));

  nhc_strobe #(.TIME_W(TIME_W)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(stb_start), .rd_i(rd_q),
    .half_i(half_eff), .we_no(we_no), .re_no(re_no),
    .sample_o(stb_sample), .done_o(stb_done), .busy_o(stb_busy));

  assign ecc_clr  = accept && we_i && (ofs == OFS_CTRL) && wdata_i[CTRL_ECC_CLR];
  assign ecc_en   = (state_q == ST_XFER) && (ph_q == PH_DATA) && !wide_q &&
                    (rd_q ? stb_sample : stb_done);
  assign ecc_byte = rd_q ? io_i[7:0] : sh_q[31:24];

  nhc_ecc u_ecc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ecc_clr), .en_i(ecc_en),
    .byte_i(ecc_byte), .ecc_o(ecc_w));

  assign ready_o = (state_q == ST_DONE);
  assign cle_o   = (state_q == ST_XFER) && (ph_q == PH_CMD);
  assign ale_o   = (state_q == ST_XFER) && (ph_q == PH_ADR);
  assign io_oe_o = (state_q == ST_XFER) && !rd_q;
  assign io_o    = wide_q ? sh_q[31:16] : {8'h00, sh_q[31:24]};

  assert_ce_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no));
  assert_strobe_needs_ce_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> (ce_no != '1));
  assert_latch_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_ready_pulse_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_no_drive_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);
  assert_ecc_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ecc_en && !ecc_clr) |=> $stable(ecc_w));
endmodule

// File: tb/tb_nand_host_ctrl.sv
module tb_nand_host_ctrl;
  localparam logic [7:0] A_CMD = 8'h00, A_ADR = 8'h04, A_DAT = 8'h08, A_ECC = 8'h10;
  localparam logic [7:0] A_B0 = 8'h30, A_B1 = 8'h34, A_B2 = 8'h38;
  localparam logic [7:0] A_CTL = 8'h40, A_STA = 8'h44, A_TIM = 8'h48, A_REV = 8'h50;
  localparam logic [31:0] REV = 32'hA5C3_0102;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ready, cle, ale, we_n, re_n, oe, rb = 1'b0;
  logic [3:0] ce_n;
  logic [15:0] io_out, io_in = '0;

  int n_chk = 0, n_err = 0, cyc = 0;

  nand_host_ctrl #(.REV_ID(REV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .ce_no(ce_n),
    .cle_o(cle), .ale_o(ale), .we_no(we_n), .re_no(re_n), .io_o(io_out),
    .io_oe_o(oe), .io_i(io_in), .rb_i(rb));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  // flash bus monitor and read-data model
  logic [15:0] w_io [64];
  logic w_cle [64], w_ale [64], w_oe [64];
  int w_low [64], w_gap [64];
  int wcnt = 0, rcnt = 0, hi_cnt = 0, rptr = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [15:0] rq [16];
  logic [7:0] eb [256];

  always @(negedge clk) begin
    if (!we_n && prev_we) begin
      if (wcnt < 64) begin
        w_io[wcnt] = io_out; w_cle[wcnt] = cle; w_ale[wcnt] = ale;
        w_oe[wcnt] = oe; w_gap[wcnt] = hi_cnt; w_low[wcnt] = 0;
      end
      wcnt++;
      hi_cnt = 0;
    end
    if (!we_n) begin
      if (wcnt > 0 && wcnt <= 64) w_low[wcnt-1]++;
    end else hi_cnt++;
    if (!re_n && prev_re) begin
      rcnt++;
      if (rptr < 16) io_in = rq[rptr];
      rptr++;
    end
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    wcnt = 0; rcnt = 0; hi_cnt = 0; rptr = 0;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int waits);
    @(negedge clk); #1;
    req = 1'b1; we = w; addr = a; wdata = d; waits = 0;
    do begin
      @(negedge clk); #1;
      waits++;
    end while (!ready && waits < 3000);
    q = rdata;
    req = 1'b0;
    if (!ready) begin
      n_err++;
      $display("FAIL R14 no ready act=0 exp=1 at offset %h", a);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q; int wt;
    bus(1'b1, a, d, q, wt);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    int wt;
    bus(1'b0, a, 32'h0, q, wt);
  endtask

  function automatic logic [31:0] ecc_ref(input int n);
    logic [15:0] lp = '0;
    logic [5:0] cp = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = eb[i];
      if (^b) for (int k = 0; k < 8; k++) begin
        if (i[k]) lp[2*k+1] = ~lp[2*k+1];
        else      lp[2*k]   = ~lp[2*k];
      end
      cp[0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
      cp[1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
      cp[2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
      cp[3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
      cp[4] ^= ^b[3:0];
      cp[5] ^= ^b[7:4];
    end
    return {cp, 2'b11, lp[15:8], lp[7:0], 8'h00};
  endfunction

  initial begin
    logic [31:0] q, ecc_keep;
    int wt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk("R1 ce_no", {28'h0, ce_n}, 32'hF);
    chk("R1 strobes", {30'h0, we_n, re_n}, 32'h3);
    chk("R1 latches/ready/oe", {28'h0, cle, ale, ready, oe}, 32'h0);
    rd(A_CTL, q); chk("R1 ctrl reset", q, 32'h8000_0000);
    rd(A_TIM, q); chk("R10 timing reset", q, 32'd2);
    rd(A_REV, q); chk("R13 revision", q, REV);
    rd(A_B0, q);  chk("R13 bank0 reset", q, 32'h0);
    rd(A_ECC, q); chk("R11 ecc reset", q, 32'h0300_0000);

    // R14 single-cycle completion for register access
    bus(1'b0, A_STA, 32'h0, q, wt);
    chk("R14 reg latency", wt, 1);
    @(negedge clk); #1;
    chk("R14 ready one cycle", {31'h0, ready}, 32'h0);

    // R9 ready/busy synchronisation
    chk("R9 status busy", q, 32'h0);
    rb = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_STA, q); chk("R9 status ready", q, 32'h0100_0000);

    // R8 released enables: no strobes
    clr_mon();
    wr(A_DAT, 32'h1111_2222);
    chk("R8 released no strobe", wcnt, 0);

    // R13 bank config readback masking
    wr(A_B0, 32'h8000_00FF);
    rd(A_B0, q); chk("R13 bank0 readback", q, 32'h8000_0000);
    wr(A_B1, 32'h8800_1234);
    rd(A_B1, q); chk("R13 bank1 readback", q, 32'h8800_0000);
    rd(A_B2, q); chk("R13 bank2 untouched", q, 32'h0);

    // R4 bank select
    wr(A_CTL, 32'h0200_0000);
    chk("R4 select bank2", {28'h0, ce_n}, 32'hB);
    rd(A_CTL, q); chk("R4 ctrl readback", q, 32'h0200_0000);
    wr(A_CTL, 32'h0000_0000);
    chk("R4 select bank0", {28'h0, ce_n}, 32'hE);

    // R2 command cycle
    clr_mon();
    wr(A_CMD, 32'h1234_5670);
    chk("R2 cmd count", wcnt, 1);
    chk("R2 cmd byte", {16'h0, w_io[0]}, 32'h70);
    chk("R2 cmd latches", {29'h0, w_cle[0], w_ale[0], w_oe[0]}, 32'b101);
    chk("R2 cmd low width", w_low[0], 2);
    chk("R2 cle after", {31'h0, cle}, 32'h0);

    // R3 address cycle
    clr_mon();
    wr(A_ADR, 32'h0000_00AB);
    chk("R3 addr count", wcnt, 1);
    chk("R3 addr byte", {16'h0, w_io[0]}, 32'hAB);
    chk("R3 addr latches", {30'h0, w_cle[0], w_ale[0]}, 32'b01);

    // R5 8-bit data write
    clr_mon();
    wr(A_DAT, 32'hDEAD_BEEF);
    chk("R5 write count", wcnt, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 write byte", {16'h0, w_io[k]}, {24'h0, 8'(32'hDEAD_BEEF >> (24 - 8*k))});
      chk("R5 write latches", {30'h0, w_cle[k], w_ale[k]}, 32'h0);
      chk("R10 low width h2", w_low[k], 2);
      if (k > 0) chk("R10 gap h2", w_gap[k], 2);
    end

    // R10 other strobe lengths
    wr(A_TIM, 32'h3);
    clr_mon();
    wr(A_DAT, 32'h0102_0304);
    chk("R10 count h3", wcnt, 4);
    chk("R10 low width h3", w_low[2], 3);
    chk("R10 gap h3", w_gap[2], 3);
    wr(A_TIM, 32'h0);
    rd(A_TIM, q); chk("R10 timing zero readback", q, 32'h0);
    clr_mon();
    wr(A_DAT, 32'h0506_0708);
    chk("R10 low width zero", w_low[1], 1);
    chk("R10 gap zero", w_gap[3], 1);
    chk("R5 last byte", {16'h0, w_io[3]}, 32'h08);
    wr(A_TIM, 32'h2);

    // R6 8-bit data read
    rq[0] = 16'h0011; rq[1] = 16'h0022; rq[2] = 16'h0033; rq[3] = 16'h0044;
    clr_mon();
    rd(A_DAT, q);
    chk("R6 read word", q, 32'h1122_3344);
    chk("R6 read count", rcnt, 4);
    chk("R6 no write strobe", wcnt, 0);

    // R7 16-bit bank
    wr(A_CTL, 32'h0100_0000);
    clr_mon();
    wr(A_DAT, 32'hCAFE_F00D);
    chk("R7 wide count", wcnt, 2);
    chk("R7 wide hi", {16'h0, w_io[0]}, 32'hCAFE);
    chk("R7 wide lo", {16'h0, w_io[1]}, 32'hF00D);
    rq[0] = 16'h1357; rq[1] = 16'h9BDF;
    clr_mon();
    rd(A_DAT, q);
    chk("R7 wide read", q, 32'h1357_9BDF);
    chk("R7 wide read count", rcnt, 2);

    // R8 disabled bank
    wr(A_CTL, 32'h0200_0000);
    rq[0] = 16'h00FF; rq[1] = 16'h00FF; rq[2] = 16'h00FF; rq[3] = 16'h00FF;
    clr_mon();
    rd(A_DAT, q);
    chk("R8 disabled read data", q, 32'h0);
    chk("R8 disabled read strobes", rcnt, 0);
    wr(A_CMD, 32'h0000_0090);
    wr(A_DAT, 32'h1234_5678);
    chk("R8 disabled write strobes", wcnt, 0);
    wr(A_CTL, 32'h8000_0000);
    chk("R4 release all", {28'h0, ce_n}, 32'hF);
    rd(A_CTL, q); chk("R4 release readback", q, 32'h8000_0000);

    // R11 full 256-byte chunk on bank0
    wr(A_TIM, 32'h1);
    wr(A_CTL, 32'h4000_0000);
    rd(A_ECC, q); chk("R12 cleared", q, 32'h0300_0000);
    for (int j = 0; j < 256; j++) eb[j] = 8'((j * 29 + 7) ^ (j >> 2));
    for (int i = 0; i < 64; i++)
      wr(A_DAT, {eb[4*i], eb[4*i+1], eb[4*i+2], eb[4*i+3]});
    rd(A_ECC, q); chk("R11 ecc 256 bytes", q, ecc_ref(256));

    // R11 partial chunk from read bytes
    wr(A_CTL, 32'h4000_0000);
    for (int k = 0; k < 12; k++) eb[k] = 8'(k * 53 + 19);
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 4; k++) rq[k] = {8'h00, eb[4*w+k]};
      clr_mon();
      rd(A_DAT, q);
      chk("R6 read pattern", q, {eb[4*w], eb[4*w+1], eb[4*w+2], eb[4*w+3]});
    end
    rd(A_ECC, q); chk("R11 ecc 12 read bytes", q, ecc_ref(12));
    ecc_keep = q;

    // R12 accesses that must not touch the ECC
    wr(A_CTL, 32'h8000_0000);
    clr_mon();
    wr(A_DAT, 32'h5A5A_C3C3);
    chk("R12 released no strobe", wcnt, 0);
    rd(A_ECC, q); chk("R12 ecc paused while released", q, ecc_keep);
    wr(A_CTL, 32'h0100_0000);
    wr(A_DAT, 32'h7E81_3C42);
    rd(A_ECC, q); chk("R12 ecc ignores wide bank", q, ecc_keep);
    wr(A_CTL, 32'h0000_0000);
    wr(A_CMD, 32'h0000_0080);
    rd(A_ECC, q); chk("R12 ecc ignores command", q, ecc_keep);
    wr(A_CTL, 32'h4000_0000);
    rd(A_ECC, q); chk("R12 clear again", q, 32'h0300_0000);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule